// File: doc/BRIEF.md
# Down-Counting Timer Channel with Two Match Points

One 32-bit timer channel. It loads a programmable start value and counts down by one on each qualified tick. It watches the live count against two compare values and against zero. Each compare or zero hit is an interrupt event. The interrupt output inverts its level on every event and a sticky status flag records that an event occurred. After the count reaches zero, the next tick loads the start value again, so the channel runs periodically.

The two compare values may be programmed in any order and hold any value. A compare value that is not below the start value counts as a compare at zero. Software can overwrite the live count while the channel runs. It can also start a channel that was enabled with a zero start value by writing a nonzero one. The tick comes from an external clock-source block as a one-cycle enable. Register writes arrive as one strobe per register that share a data bus.

Top module: `dmt_channel`

## Requirements
- R1: While enable_i is high and the reload value is nonzero, each cycle with tick_i high and a nonzero count lowers count_o by exactly one.
- R2: A tick that finds the count at zero loads the reload value into the count and raises no event.
- R3: A decrement that lands on a nonzero effective compare value raises one event. This holds whichever compare register holds the larger value, and two equal compare values still raise only one event.
- R4: The effective value of a compare register is its own value when that is below the reload value, and zero otherwise.
- R5: A decrement that lands on zero raises an event when ovf_irq_en_i is high or either effective compare value is zero. Otherwise it raises none.
- R6: Each event inverts irq_o in the cycle after the tick and sets sts_o. sts_o then stays high until reset.
- R7: While enable_i is low, count_o shows the reload value and ticks raise no event. The cycle after enable_i rises, the count equals the reload value.
- R8: A count write while enable_i is high makes count_o equal wdata_i in the next cycle. A count write while enable_i is low changes nothing.
- R9: A reload write of a nonzero value while the reload is zero and enable_i is high loads that value into the count. Any other reload write leaves the running count unchanged until the next wrap.
- R10: Reset clears the count, the reload value, both compare values, irq_o and sts_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle count enable from the selected clock source |
| enable_i | input | 1 | Channel run enable |
| ovf_irq_en_i | input | 1 | Raise an event whenever the count reaches zero |
| wr_count_i | input | 1 | Write strobe for the live count |
| wr_reload_i | input | 1 | Write strobe for the reload value |
| wr_match_a_i | input | 1 | Write strobe for compare register A |
| wr_match_b_i | input | 1 | Write strobe for compare register B |
| wdata_i | input | CNT_W | Write data shared by all strobes |
| count_o | output | CNT_W | Live count when enabled, reload value when disabled |
| irq_o | output | 1 | Interrupt level, inverted on each event |
| sts_o | output | 1 | Sticky event flag |

## Verification
The bench programs the smaller compare value first and then the larger. A design that sorts the compare values by register slot would fire in the wrong order or miss an event. The bench uses compare values equal to and above the reload value, and a zero compare with the overflow enable off. A design that compares raw values would never fire at zero. Equal compare values must produce one toggle, not two, since a double toggle leaves irq_o unchanged. The bench writes the reload while the channel runs and also starts a zero-reload channel. A wrong design either restarts the running count or never starts. After a reset that follows nonzero compare values, the next run must fire only at zero. A design that keeps its compare values across reset would fire early.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
  localparam int unsigned NUM_MATCH = 2;

  typedef enum logic [2:0] {
    LD_HOLD,
    LD_WRITE,
    LD_START,
    LD_ENABLE,
    LD_WRAP,
    LD_STEP
  } cnt_sel_e;
endpackage

// File: rtl/dmt_wreg.sv
module dmt_wreg #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/dmt_match_cmp.sv
module dmt_match_cmp #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] match_i,
  input  logic [W-1:0] reload_i,
  input  logic [W-1:0] probe_i,
  output logic         eff_zero_o,
  output logic         hit_nz_o
);
  logic [W-1:0] eff;

  // out-of-range compare folds onto zero
  assign eff        = (match_i < reload_i) ? match_i : '0;
  assign eff_zero_o = (eff == '0);
  assign hit_nz_o   = !eff_zero_o && (probe_i == eff);
endmodule

// File: rtl/dmt_counter.sv
module dmt_counter
  import dmt_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  cnt_sel_e     sel_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] reload_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] dec_o
);
  logic [W-1:0] cnt_d;

  assign dec_o = cnt_o - 1'b1;

  always_comb begin
    unique case (sel_i)
      LD_WRITE, LD_START:  cnt_d = wdata_i;
      LD_ENABLE, LD_WRAP:  cnt_d = reload_i;
      LD_STEP:             cnt_d = dec_o;
      default:             cnt_d = cnt_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= cnt_d;
  end
endmodule

// File: rtl/dmt_irq.sv
module dmt_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic event_i,
  output logic irq_o,
  output logic sts_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o <= 1'b0;
      sts_o <= 1'b0;
    end else if (event_i) begin
      irq_o <= ~irq_o;
      sts_o <= 1'b1;
    end
  end
endmodule

// File: rtl/dmt_channel.sv
module dmt_channel
  import dmt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             enable_i,
  input  logic             ovf_irq_en_i,
  input  logic             wr_count_i,
  input  logic             wr_reload_i,
  input  logic             wr_match_a_i,
  input  logic             wr_match_b_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o,
  output logic             sts_o
);
  logic [CNT_W-1:0]                reload_q;
  logic [NUM_MATCH-1:0][CNT_W-1:0] match_q;
  logic [NUM_MATCH-1:0]            wr_match;
  logic [NUM_MATCH-1:0]            eff_zero;
  logic [NUM_MATCH-1:0]            hit_nz;
  logic [CNT_W-1:0]                cnt_q;
  logic [CNT_W-1:0]                cnt_dec;
  logic                            en_q;
  logic                            reload_zero;
  logic                            start_ld;
  logic                            tick_ok;
  logic                            land_zero;
  logic                            event_d;
  cnt_sel_e                        sel;

  assign wr_match = {wr_match_b_i, wr_match_a_i};

  dmt_wreg #(.W(CNT_W)) u_reload (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (wr_reload_i),
    .d_i   (wdata_i),
    .q_o   (reload_q)
  );

  for (genvar m = 0; m < NUM_MATCH; m++) begin : g_match
    dmt_wreg #(.W(CNT_W)) u_reg (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .we_i  (wr_match[m]),
      .d_i   (wdata_i),
      .q_o   (match_q[m])
    );
    dmt_match_cmp #(.W(CNT_W)) u_cmp (
      .match_i   (match_q[m]),
      .reload_i  (reload_q),
      .probe_i   (cnt_dec),
      .eff_zero_o(eff_zero[m]),
      .hit_nz_o  (hit_nz[m])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= enable_i;
  end

  assign reload_zero = (reload_q == '0);
  assign start_ld    = wr_reload_i && reload_zero && (wdata_i != '0) && enable_i;
  assign tick_ok     = tick_i && enable_i && !reload_zero;

  always_comb begin
    if (wr_count_i && enable_i)   sel = LD_WRITE;
    else if (start_ld)            sel = LD_START;
    else if (enable_i && !en_q)   sel = LD_ENABLE;
    else if (tick_ok && cnt_q == '0) sel = LD_WRAP;
    else if (tick_ok)             sel = LD_STEP;
    else                          sel = LD_HOLD;
  end

  dmt_counter #(.W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (sel),
    .wdata_i (wdata_i),
    .reload_i(reload_q),
    .cnt_o   (cnt_q),
    .dec_o   (cnt_dec)
  );

  assign land_zero = (cnt_dec == '0);
  assign event_d   = (sel == LD_STEP) &&
                     (land_zero ? (ovf_irq_en_i || (|eff_zero)) : (|hit_nz));

  dmt_irq u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .event_i(event_d),
    .irq_o  (irq_o),
    .sts_o  (sts_o)
  );

  assign count_o = enable_i ? cnt_q : reload_q;
endmodule

// File: rtl/dmt_channel_chk.sv
module dmt_channel_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             enable_i,
  input logic             en_q,
  input logic             wr_count_i,
  input logic             wr_reload_i,
  input logic [CNT_W-1:0] reload_q,
  input logic [CNT_W-1:0] count_o,
  input logic             irq_o,
  input logic             sts_o
);
  logic plain_tick;
  assign plain_tick = tick_i && enable_i && en_q && !wr_count_i && !wr_reload_i &&
                      (reload_q != '0);

  a_r1_step_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (plain_tick && count_o != '0) |=> (!enable_i || count_o == $past(count_o) - 1'b1));

  a_r2_wrap_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (plain_tick && count_o == '0) |=> (!enable_i || count_o == $past(reload_q)));

  a_r6_toggle_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(irq_o) |-> $past(tick_i && enable_i));

  a_r6_toggle_sets_sts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(irq_o) |-> sts_o);

  a_r6_sts_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_o |=> sts_o);
endmodule

bind dmt_channel dmt_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .enable_i   (enable_i),
  .en_q       (en_q),
  .wr_count_i (wr_count_i),
  .wr_reload_i(wr_reload_i),
  .reload_q   (reload_q),
  .count_o    (count_o),
  .irq_o      (irq_o),
  .sts_o      (sts_o)
);

// File: tb/dmt_channel_bench.sv
module dmt_channel_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b0, enable_i = 1'b0, ovf_irq_en_i = 1'b0;
  logic wr_count_i = 1'b0, wr_reload_i = 1'b0, wr_match_a_i = 1'b0, wr_match_b_i = 1'b0;
  logic [W-1:0] wdata_i = '0;
  logic [W-1:0] count_o;
  logic irq_o, sts_o;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmt_channel #(.CNT_W(W)) u_dmt_channel (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .enable_i(enable_i),
    .ovf_irq_en_i(ovf_irq_en_i), .wr_count_i(wr_count_i), .wr_reload_i(wr_reload_i),
    .wr_match_a_i(wr_match_a_i), .wr_match_b_i(wr_match_b_i), .wdata_i(wdata_i),
    .count_o(count_o), .irq_o(irq_o), .sts_o(sts_o)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; tick_i = 0; enable_i = 0; ovf_irq_en_i = 0;
    wr_count_i = 0; wr_reload_i = 0; wr_match_a_i = 0; wr_match_b_i = 0; wdata_i = '0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  // kind: 0 count, 1 reload, 2 compare A, 3 compare B
  task automatic wr(input int kind, input logic [W-1:0] val);
    @(negedge clk);
    wdata_i = val;
    wr_count_i = (kind == 0); wr_reload_i = (kind == 1);
    wr_match_a_i = (kind == 2); wr_match_b_i = (kind == 3);
    @(negedge clk);
    wr_count_i = 0; wr_reload_i = 0; wr_match_a_i = 0; wr_match_b_i = 0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_i = 1'b1;
    repeat (n) @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic set_en(input logic v);
    @(negedge clk);
    enable_i = v;
    @(negedge clk);
  endtask

  task automatic t_disabled();
    do_reset();
    chk("R10 reset count", count_o, 0);
    chk("R10 reset irq", irq_o, 0);
    chk("R10 reset sts", sts_o, 0);
    ovf_irq_en_i = 1'b1;
    wr(1, 3);
    chk("R7 disabled shows reload", count_o, 3);
    ticks(5);
    chk("R7 ticks ignored irq", irq_o, 0);
    chk("R7 ticks ignored count", count_o, 3);
    wr(1, 10);
    set_en(1'b1);
    chk("R7 enable loads reload", count_o, 10);
    ticks(3);
    chk("R1 three ticks", count_o, 7);
  endtask

  task automatic t_order();
    do_reset();
    wr(1, 10); wr(2, 3); wr(3, 7);
    set_en(1'b1);
    ticks(3);
    chk("R3 larger compare count", count_o, 7);
    chk("R3 larger compare irq", irq_o, 1);
    ticks(4);
    chk("R3 smaller compare count", count_o, 3);
    chk("R3 smaller compare irq", irq_o, 0);
    ticks(3);
    chk("R5 zero no ovf count", count_o, 0);
    chk("R5 zero no ovf irq", irq_o, 0);
    ticks(1);
    chk("R2 wrap count", count_o, 10);
    chk("R2 wrap no event", irq_o, 0);
    ticks(3);
    chk("R2 second period irq", irq_o, 1);
  endtask

  task automatic t_fold();
    do_reset();
    wr(1, 8); wr(2, 8); wr(3, 20);
    set_en(1'b1);
    ticks(7);
    chk("R4 no early event", irq_o, 0);
    ticks(1);
    chk("R4 folded compare at zero count", count_o, 0);
    chk("R4 folded compare single toggle", irq_o, 1);
  endtask

  task automatic t_ovf();
    do_reset();
    ovf_irq_en_i = 1'b1;
    wr(1, 5); wr(2, 4); wr(3, 2);
    set_en(1'b1);
    ticks(1);
    chk("R3 compare 4", irq_o, 1);
    ticks(2);
    chk("R3 compare 2", irq_o, 0);
    ticks(2);
    chk("R5 ovf zero event", irq_o, 1);
    chk("R6 sts set", sts_o, 1);
  endtask

  task automatic t_zero_match();
    do_reset();
    wr(1, 5); wr(2, 0); wr(3, 3);
    set_en(1'b1);
    ticks(2);
    chk("R3 compare 3", irq_o, 1);
    ticks(3);
    chk("R5 zero compare event", irq_o, 0);
    chk("R5 zero compare count", count_o, 0);
  endtask

  task automatic t_count_wr();
    do_reset();
    wr(1, 20);
    set_en(1'b1);
    ticks(2);
    chk("R1 count 18", count_o, 18);
    wr(0, 6);
    chk("R8 count write", count_o, 6);
    ticks(1);
    chk("R8 counts from written", count_o, 5);
    set_en(1'b0);
    wr(0, 3);
    chk("R8 write while disabled ignored", count_o, 20);
    set_en(1'b1);
    chk("R7 re-enable loads reload", count_o, 20);
  endtask

  task automatic t_reload_start();
    do_reset();
    set_en(1'b1);
    ticks(3);
    chk("R9 zero reload idles count", count_o, 0);
    chk("R9 zero reload no event", irq_o, 0);
    wr(1, 6);
    chk("R9 start from zero reload", count_o, 6);
    ticks(2);
    chk("R9 running", count_o, 4);
    wr(1, 9);
    chk("R9 running reload write keeps count", count_o, 4);
    ticks(4);
    chk("R9 reaches zero", count_o, 0);
    ticks(1);
    chk("R9 new reload at wrap", count_o, 9);
  endtask

  task automatic t_equal_and_reset();
    do_reset();
    wr(1, 10); wr(2, 5); wr(3, 5);
    set_en(1'b1);
    ticks(5);
    chk("R3 equal compares one toggle", irq_o, 1);
    ticks(2);
    chk("R6 sts sticky", sts_o, 1);
    chk("R6 level held", irq_o, 1);
    do_reset();
    wr(1, 6);
    set_en(1'b1);
    ticks(1);
    chk("R10 compares cleared", irq_o, 0);
    ticks(5);
    chk("R10 zero-compare fires at zero", irq_o, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_disabled();
    t_order();
    t_fold();
    t_ovf();
    t_zero_match();
    t_count_wr();
    t_reload_start();
    t_equal_and_reset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule